// File: doc/BRIEF.md
# Routed Level Interrupt Collector

This block gathers nine level-sensitive interrupt sources and presents them on three active-high request lines toward a host interrupt controller. A shared polarity word says, for each source, whether its input is active when high or when low. Three sources ignore that word and have a polarity fixed in hardware. Every request line owns one 32-bit register. The low half of that register holds per-source enables. The upper half holds per-source pending flags that software clears by writing ones.

Every line latches pending flags for every source, whether or not the source is enabled there. A line raises its request only for sources it has enabled. This lets one source be steered to any number of the three lines, and lets software poll the cause of a request from the status half of the line's register. The register port takes a single-cycle write strobe. Read data is registered and returned one cycle after the read strobe.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the polarity word, every enable bit, every pending flag, the read data and all three request outputs are zero.
- R2: The polarity word sits at byte offset 0x0 in bits 8:0, one bit per source. A 1 makes the source active-high and a 0 makes it active-low. Bits 31:9 read as zero and ignore writes.
- R3: Sources 1 and 8 are always active-high and source 2 is always active-low, whatever the polarity word holds. The polarity bits for those sources still read back as written.
- R4: The registers for lines 0, 1 and 2 sit at byte offsets 0x4, 0x8 and 0xC. Bits 8:0 are the enable bits for sources 0 to 8 and are written directly. Bits 24:16 are the pending flags for sources 0 to 8. All other bits read as zero.
- R5: In every line register, the pending flag for source n is set on the clock edge that samples source n active at its effective polarity, whether or not the source is enabled on that line.
- R6: Writing 1 to pending bit 16+n of a line register clears that flag only if source n is inactive in that cycle. If the source is still active, the flag stays set. Writing 0 to a pending bit leaves it unchanged.
- R7: Request output k is high in the cycle after the register of line k holds a pending flag whose enable bit is also set, and low otherwise.
- R8: Each line keeps its own enables and flags. Clearing a flag or an enable on one line leaves the other lines unchanged.
- R9: Read data appears one cycle after the read strobe and is zero in any cycle that follows no read strobe. Offsets other than 0x0, 0x4, 0x8 and 0xC read as zero, and writes to them change nothing.
- R10: A write to a line register updates its enables without setting or clearing any pending flag except through the write-one-to-clear rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte offset of the register access |
| wr_en | input | 1 | Single-cycle write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; data follows one cycle later |
| rdata | output | 32 | Registered read data |
| src_in | input | 9 | Raw interrupt source levels |
| irq_out | output | 3 | Active-high request lines 0 to 2 |

## Verification
Two functions can act on one pending flag in the same cycle: a write-one-to-clear from software and a fresh activation by a source that is still asserted. The bench issues a clear while the source is held active and expects the flag to survive. It then drops the source and clears again, expecting the flag to go to zero on that line only. A read and a write to the same line register are also issued in one cycle, and the returned word must show the value before the write. A behavioural model updated on every clock edge judges the request lines and the read data throughout.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // default geometry of the collector
  localparam int unsigned DEF_N_SRC    = 9;
  localparam int unsigned DEF_N_LINE   = 3;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_ADDR_W   = 8;
  localparam int unsigned DEF_STAT_LSB = 16;

  // sources whose polarity is wired, and the level each one is active at
  localparam logic [DEF_N_SRC-1:0] DEF_FIX_MASK = 9'b1_0000_0110;
  localparam logic [DEF_N_SRC-1:0] DEF_FIX_HIGH = 9'b1_0000_0010;
endpackage

// File: rtl/irq_pol_unit.sv
module irq_pol_unit #(
  parameter int unsigned N_SRC = 9,
  parameter logic [N_SRC-1:0] FIX_MASK = '0,
  parameter logic [N_SRC-1:0] FIX_HIGH = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [N_SRC-1:0] cfg_wdata,
  input  logic [N_SRC-1:0] src_in,
  output logic [N_SRC-1:0] cfg_q,
  output logic [N_SRC-1:0] act
);
  logic [N_SRC-1:0] eff_pol;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  // per source: wired polarity or the programmed one
  for (genvar i = 0; i < N_SRC; i++) begin : g_pol
    if (FIX_MASK[i]) begin : g_fixed
      assign eff_pol[i] = FIX_HIGH[i];
    end else begin : g_prog
      assign eff_pol[i] = cfg_q[i];
    end
  end

  // active when the level matches the effective polarity
  assign act = ~(src_in ^ eff_pol);
endmodule

// File: rtl/irq_line_slice.sv
module irq_line_slice #(
  parameter int unsigned N_SRC = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [N_SRC-1:0] wen,
  input  logic [N_SRC-1:0] wclr,
  input  logic [N_SRC-1:0] act,
  output logic [N_SRC-1:0] en_q,
  output logic [N_SRC-1:0] stat_q,
  output logic             irq_q
);
  logic [N_SRC-1:0] clr_mask;

  assign clr_mask = we ? wclr : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (we) en_q <= wen;
      // an active source wins over a same-cycle clear
      stat_q <= (stat_q & ~clr_mask) | act;
      irq_q  <= |(stat_q & en_q);
    end
  end

  AST_STAT_CAPTURES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(act)) == $past(act))); // R5

  AST_CLEAR_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (we && |(wclr & ~act)) |=> ((stat_q & $past(wclr & ~act)) == '0)); // R6

  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(en_q) != '0)); // R7
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int unsigned N_SRC    = 9,
  parameter int unsigned N_LINE   = 3,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned STAT_LSB = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  logic                    cfg_hit,
  input  logic [N_LINE-1:0]       line_hit,
  input  logic [N_SRC-1:0]        cfg_q,
  input  logic [N_LINE*N_SRC-1:0] en_flat,
  input  logic [N_LINE*N_SRC-1:0] stat_flat,
  output logic [DATA_W-1:0]       rdata
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    if (cfg_hit) word[N_SRC-1:0] = cfg_q;
    for (int k = 0; k < N_LINE; k++) begin
      if (line_hit[k]) begin
        word[N_SRC-1:0]          = en_flat[k*N_SRC +: N_SRC];
        word[STAT_LSB +: N_SRC]  = stat_flat[k*N_SRC +: N_SRC];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= word;
    else            rdata <= '0;
  end

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> (rdata == '0)); // R9

  AST_DECODE_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({line_hit, cfg_hit})); // R9
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SRC    = DEF_N_SRC,
  parameter int unsigned N_LINE   = DEF_N_LINE,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned STAT_LSB = DEF_STAT_LSB,
  parameter logic [N_SRC-1:0] FIX_MASK = DEF_FIX_MASK,
  parameter logic [N_SRC-1:0] FIX_HIGH = DEF_FIX_HIGH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_SRC-1:0]  src_in,
  output logic [N_LINE-1:0] irq_out
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic                    aligned;
  logic [WORD_W-1:0]       word_idx;
  logic                    cfg_hit;
  logic [N_LINE-1:0]       line_hit;
  logic [N_SRC-1:0]        cfg_q;
  logic [N_SRC-1:0]        act;
  logic [N_LINE*N_SRC-1:0] en_flat;
  logic [N_LINE*N_SRC-1:0] stat_flat;
  logic [N_LINE-1:0]       irq_vec;
  logic                    unused_wdata_bits;

  assign aligned  = (addr[1:0] == 2'b00);
  assign word_idx = addr[ADDR_W-1:2];
  assign cfg_hit  = aligned && (word_idx == '0);
  assign unused_wdata_bits = ^wdata;

  irq_pol_unit #(
    .N_SRC    (N_SRC),
    .FIX_MASK (FIX_MASK),
    .FIX_HIGH (FIX_HIGH)
  ) u_pol (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (wr_en && cfg_hit),
    .cfg_wdata (wdata[N_SRC-1:0]),
    .src_in    (src_in),
    .cfg_q     (cfg_q),
    .act       (act)
  );

  for (genvar k = 0; k < N_LINE; k++) begin : g_line
    assign line_hit[k] = aligned && (word_idx == WORD_W'(k + 1));

    irq_line_slice #(
      .N_SRC (N_SRC)
    ) u_slice (
      .clk    (clk),
      .rst    (rst),
      .we     (wr_en && line_hit[k]),
      .wen    (wdata[N_SRC-1:0]),
      .wclr   (wdata[STAT_LSB +: N_SRC]),
      .act    (act),
      .en_q   (en_flat[k*N_SRC +: N_SRC]),
      .stat_q (stat_flat[k*N_SRC +: N_SRC]),
      .irq_q  (irq_vec[k])
    );
  end

  irq_read_mux #(
    .N_SRC    (N_SRC),
    .N_LINE   (N_LINE),
    .DATA_W   (DATA_W),
    .STAT_LSB (STAT_LSB)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .cfg_hit   (cfg_hit),
    .line_hit  (line_hit),
    .cfg_q     (cfg_q),
    .en_flat   (en_flat),
    .stat_flat (stat_flat),
    .rdata     (rdata)
  );

  assign irq_out = irq_vec;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (irq_out == '0 && rdata == '0)); // R1
endmodule

// File: tb/irq_route_ctrl_bench.sv
`timescale 1ns/1ps
module irq_route_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [8:0]  src_in = 9'h0FD;
  logic [2:0]  irq_out;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  irq_route_ctrl u_irq_route_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .src_in(src_in), .irq_out(irq_out)
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference ----------------
  logic [8:0]  m_cfg;
  logic [8:0]  m_en [3];
  logic [8:0]  m_st [3];
  logic [2:0]  m_irq;
  logic [31:0] m_rd;

  function automatic bit src_active(int n, logic [8:0] cfg, logic [8:0] s);
    bit hi;
    if (n == 1 || n == 8) hi = 1'b1;
    else if (n == 2)      hi = 1'b0;
    else                  hi = cfg[n];
    return hi ? s[n] : !s[n];
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    logic [31:0] v = '0;
    case (a)
      8'h00: v = {23'd0, m_cfg};
      8'h04: v = {7'd0, m_st[0], 7'd0, m_en[0]};
      8'h08: v = {7'd0, m_st[1], 7'd0, m_en[1]};
      8'h0C: v = {7'd0, m_st[2], 7'd0, m_en[2]};
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = '0; m_irq = '0; m_rd = '0;
      for (int k = 0; k < 3; k++) begin m_en[k] = '0; m_st[k] = '0; end
    end else begin
      logic [8:0] a_now;
      for (int n = 0; n < 9; n++) a_now[n] = src_active(n, m_cfg, src_in);
      for (int k = 0; k < 3; k++) m_irq[k] = |(m_st[k] & m_en[k]);
      m_rd = rd_en ? model_read(addr) : 32'd0;
      for (int k = 0; k < 3; k++) begin
        if (wr_en && addr == 8'(4 * (k + 1))) begin
          m_st[k] = m_st[k] & ~wdata[24:16];
          m_en[k] = wdata[8:0];
        end
        m_st[k] = m_st[k] | a_now;
      end
      if (wr_en && addr == 8'h00) m_cfg = wdata[8:0];
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      checks++;
      if (irq_out !== m_irq) begin
        bad++;
        $display("FAIL R7 irq_out got=%b exp=%b", irq_out, m_irq);
      end
      checks++;
      if (rdata !== m_rd) begin
        bad++;
        $display("FAIL R9 rdata got=%h exp=%h", rdata, m_rd);
      end
    end
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      bad++;
      $display("FAIL watchdog got=%0d exp<=20000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wrrd(input logic [7:0] a, input logic [31:0] wd, output logic [31:0] d);
    @(negedge clk); addr = a; wdata = wd; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    check("R1 irq_out", {29'd0, irq_out}, 32'd0);
    rd(8'h00, d); check("R1 cfg", d, 32'd0);
    rd(8'h04, d); check("R1 line0", d, 32'd0);

    // R2: polarity word, upper bits read zero
    wr(8'h00, 32'hFFFF_FFFF);
    src_in = 9'h004;
    rd(8'h00, d); check("R2 cfg readback", d, 32'h0000_01FF);
    wr(8'h04, 32'h01FF_0000);
    wr(8'h08, 32'h01FF_0000);
    wr(8'h0C, 32'h01FF_0000);
    rd(8'h04, d); check("R6 cleared idle", d, 32'd0);

    // R4: enable field and zero bits; R9: unmapped offsets
    wr(8'h08, 32'hFFFF_01A5);
    rd(8'h08, d); check("R4 line1 fields", d, 32'h0000_01A5);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); check("R9 unmapped", d, 32'd0);
    rd(8'h06, d); check("R9 unaligned", d, 32'd0);

    // R5 and R8: one source routed to lines 0 and 2
    wr(8'h04, 32'h0000_0010);
    wr(8'h0C, 32'h0000_0010);
    src_in[4] = 1'b1;
    idle(2);
    check("R8 irq lines 0 and 2", {29'd0, irq_out}, 32'd5);
    rd(8'h08, d); check("R5 flag without enable", d, 32'h0010_01A5);

    // R6: clear while active keeps the flag
    wr(8'h04, 32'h0010_0010);
    rd(8'h04, d); check("R6 clear vs active", d, 32'h0010_0010);
    src_in[4] = 1'b0;
    idle(1);
    wrrd(8'h04, 32'h0010_0010, d);
    check("R9 read sees pre-write value", d, 32'h0010_0010);
    idle(2);
    rd(8'h04, d); check("R6 clear after idle", d, 32'h0000_0010);
    check("R8 line2 unaffected", {29'd0, irq_out}, 32'd4);
    wr(8'h0C, 32'h0000_0010);
    rd(8'h0C, d); check("R10 zero write keeps flag", d, 32'h0010_0010);

    // R3: source 2 active-low while polarity word says high
    src_in[2] = 1'b0;
    idle(2);
    rd(8'h08, d); check("R3 source2 low-active", d, 32'h0014_01A5);
    check("R7 line1 request", {31'd0, irq_out[1]}, 32'd1);
    src_in[2] = 1'b1;
    idle(1);
    wr(8'h08, 32'h0014_01A5);
    rd(8'h08, d); check("R6 line1 cleared", d, 32'h0000_01A5);

    // R3: source 8 high-active while polarity word says low
    wr(8'h00, 32'h0000_0000);
    src_in = 9'h0FD;
    idle(1);
    wr(8'h04, 32'h01FF_0010);
    wr(8'h08, 32'h01FF_01A5);
    wr(8'h0C, 32'h01FF_0010);
    rd(8'h04, d); check("R3 line0 quiet", d, 32'h0000_0010);
    src_in[8] = 1'b1;
    idle(2);
    rd(8'h04, d); check("R3 source8 high-active", d, 32'h0100_0010);
    check("R7 line1 enabled on 8", {31'd0, irq_out[1]}, 32'd1);
    check("R7 line0 not enabled on 8", {31'd0, irq_out[0]}, 32'd0);

    idle(3);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule